// File: doc/BRIEF.md
# Issue Resource Reservation Timers

This block keeps track of the execution resources an instruction takes when it issues. Each SIMD has two countdown timers: one for the ALU pipeline and one for its issue slot. There are two issue-slot timers for the memory units, one global and one shared. Each memory side also has a timer for the bus that carries operands from the register file to that memory. When an issue strobe arrives, the opcode class selects which timers are loaded and with what length. The block also keeps saturating counters of memory requests that are in flight: a total, plus separate read and write counts for the global side and for the local side.

A scheduler reads the ready flags to decide whether a candidate instruction may issue. A flag is high when its timer has counted down to zero. The scheduler reads the counters to enforce ordering between reads and writes. The completion paths lower the counters through one-cycle decrement strobes. Each timer is a small state machine with two states, `T_IDLE` and `T_BUSY`. Its transitions are LOAD (idle to busy on a nonzero load), RELOAD (busy to busy on a new load), TICK (busy to busy while the count is above one) and EXPIRE (busy to idle when the last cycle is counted). A load of zero keeps the timer in `T_IDLE`.

Top module: `issue_resv_timers`

## Requirements
- R1: After reset every ready flag is 1 and every counter reads 0.
- R2: An issue of class 1 (ALU-type: arithmetic, branch, return, special, kernel argument) loads the ALU timer of the selected SIMD with `alu_bypass` and that SIMD's issue-slot timer with `issue_period`. No other timer changes.
- R3: An issue of class 2 (barrier) loads only the selected SIMD's issue-slot timer with `issue_period`.
- R4: A memory read (classes 3, 6, 9, 12) reserves its bus for 4 cycles. A memory write or atomic (classes 4, 5, 7, 8, 10, 11, 13) reserves it for 8 cycles.
- R5: Every memory issue loads the issue-slot timer of its memory unit (global or shared) with `issue_period`. Global is classes 3–5, shared is classes 6–8.
- R6: A read adds one to the total and to the read counter of its space. A write adds one to the total and to the write counter. An atomic adds one to the total and to both the read and the write counters.
- R7: Private-memory classes 9 (read), 10 (write) and 11 (atomic) use the global bus, the global issue slot and the global counters.
- R8: Flat classes 12 (read) and 13 (write) use the shared bus and shared slot when `flat_shared` is 1, and the global ones otherwise. Their counts always go to the global counters.
- R9: A nonzero timer falls by one each cycle, and its ready flag is high exactly when it is zero. A load of 0 leaves the flag high.
- R10: An increment and a decrement on the same counter in the same cycle leave it unchanged. A decrement alone lowers it by one.
- R11: Class 0 (no-op), reserved classes 14 and 15, and any cycle with `issue_valid` low change no timer and no counter.
- R12: A counter holds at its maximum (all ones) when incremented and holds at zero when decremented.
- R13: A load on a busy timer replaces the remaining count with the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue strobe |
| issue_simd | input | SIMD_W | SIMD that issues |
| issue_class | input | 4 | Opcode class code |
| flat_shared | input | 1 | Flat access resolved to shared memory |
| issue_period | input | TIMER_W | Issue-slot occupancy in cycles |
| alu_bypass | input | TIMER_W | ALU pipe occupancy in cycles |
| dec_total | input | 1 | Completion strobe for the total counter |
| dec_gm_rd | input | 1 | Completion strobe, global reads |
| dec_gm_wr | input | 1 | Completion strobe, global writes |
| dec_lm_rd | input | 1 | Completion strobe, local reads |
| dec_lm_wr | input | 1 | Completion strobe, local writes |
| alu_ready | output | NUM_SIMD | ALU pipe free, per SIMD |
| simd_slot_ready | output | NUM_SIMD | Issue slot free, per SIMD |
| gm_slot_ready | output | 1 | Global memory unit issue slot free |
| lm_slot_ready | output | 1 | Shared memory unit issue slot free |
| gm_bus_ready | output | 1 | Register-file-to-global bus free |
| lm_bus_ready | output | 1 | Register-file-to-local bus free |
| cnt_total | output | CNT_W | In-flight memory requests, all |
| cnt_gm_rd | output | CNT_W | In-flight global reads |
| cnt_gm_wr | output | CNT_W | In-flight global writes |
| cnt_lm_rd | output | CNT_W | In-flight local reads |
| cnt_lm_wr | output | CNT_W | In-flight local writes |

## Verification
On every cycle the assertions check the following: the timer load, reload and one-per-cycle countdown; the idle state implying a zero count; counter hold on a collision; saturation at both ends; the local counters staying still under flat and private traffic; and the shared slot going busy after a shared read. Only the bench scenarios can show that the right timer is chosen for each class and SIMD. They also show the 4 and 8 cycle bus lengths, the flat target steering, that no-op and reserved codes have no effect, and the full count sequences under long runs of traffic.

// File: rtl/resv_pkg.sv
package resv_pkg;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_ALU     = 4'd1,
        OP_BARRIER = 4'd2,
        OP_GLB_RD  = 4'd3,
        OP_GLB_WR  = 4'd4,
        OP_GLB_AT  = 4'd5,
        OP_SHR_RD  = 4'd6,
        OP_SHR_WR  = 4'd7,
        OP_SHR_AT  = 4'd8,
        OP_PRV_RD  = 4'd9,
        OP_PRV_WR  = 4'd10,
        OP_PRV_AT  = 4'd11,
        OP_FLAT_RD = 4'd12,
        OP_FLAT_WR = 4'd13
    } op_class_e;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_BUSY = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic ld_alu;
        logic ld_simd_slot;
        logic ld_gm_slot;
        logic ld_lm_slot;
        logic ld_gm_bus;
        logic ld_lm_bus;
        logic bus_long;
        logic inc_total;
        logic inc_gm_rd;
        logic inc_gm_wr;
        logic inc_lm_rd;
        logic inc_lm_wr;
    } resv_req_t;

    localparam int NUM_CNT = 5;
    localparam int CI_TOTAL = 0;
    localparam int CI_GM_RD = 1;
    localparam int CI_GM_WR = 2;
    localparam int CI_LM_RD = 3;
    localparam int CI_LM_WR = 4;

endpackage

// File: rtl/resv_decode.sv
module resv_decode
    import resv_pkg::*;
(
    input  logic       issue_valid,
    input  logic [3:0] issue_class,
    input  logic       flat_shared,
    output resv_req_t  req
);

    logic is_rd;
    logic is_wr;
    logic to_local;
    logic count_local;
    logic is_mem;

    always_comb begin
        is_rd       = 1'b0;
        is_wr       = 1'b0;
        to_local    = 1'b0;
        count_local = 1'b0;
        is_mem      = 1'b0;
        req         = '0;
        if (issue_valid) begin
            unique case (issue_class)
                OP_ALU: begin
                    req.ld_alu       = 1'b1;
                    req.ld_simd_slot = 1'b1;
                end
                OP_BARRIER: req.ld_simd_slot = 1'b1;
                OP_GLB_RD, OP_PRV_RD: begin
                    is_mem = 1'b1; is_rd = 1'b1;
                end
                OP_GLB_WR, OP_PRV_WR: begin
                    is_mem = 1'b1; is_wr = 1'b1;
                end
                OP_GLB_AT, OP_PRV_AT: begin
                    is_mem = 1'b1; is_rd = 1'b1; is_wr = 1'b1;
                end
                OP_SHR_RD: begin
                    is_mem = 1'b1; is_rd = 1'b1;
                    to_local = 1'b1; count_local = 1'b1;
                end
                OP_SHR_WR: begin
                    is_mem = 1'b1; is_wr = 1'b1;
                    to_local = 1'b1; count_local = 1'b1;
                end
                OP_SHR_AT: begin
                    is_mem = 1'b1; is_rd = 1'b1; is_wr = 1'b1;
                    to_local = 1'b1; count_local = 1'b1;
                end
                OP_FLAT_RD: begin
                    is_mem = 1'b1; is_rd = 1'b1;
                    to_local = flat_shared;
                end
                OP_FLAT_WR: begin
                    is_mem = 1'b1; is_wr = 1'b1;
                    to_local = flat_shared;
                end
                default: ;
            endcase
            if (is_mem) begin
                req.ld_gm_bus  = !to_local;
                req.ld_lm_bus  = to_local;
                req.ld_gm_slot = !to_local;
                req.ld_lm_slot = to_local;
                req.bus_long   = is_wr;
                req.inc_total  = 1'b1;
                req.inc_gm_rd  = is_rd && !count_local;
                req.inc_gm_wr  = is_wr && !count_local;
                req.inc_lm_rd  = is_rd && count_local;
                req.inc_lm_wr  = is_wr && count_local;
            end
        end
    end

endmodule

// File: rtl/resv_timer.sv
module resv_timer
    import resv_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         ready
);

    localparam logic [W-1:0] ONE = W'(1);

    tmr_state_e   state_q, state_n;
    logic [W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            T_IDLE: begin
                if (load) begin
                    cnt_n   = value;
                    state_n = (value != '0) ? T_BUSY : T_IDLE;
                end
            end
            T_BUSY: begin
                if (load) begin
                    cnt_n   = value;
                    state_n = (value != '0) ? T_BUSY : T_IDLE;
                end else begin
                    cnt_n   = cnt_q - ONE;
                    state_n = (cnt_q == ONE) ? T_IDLE : T_BUSY;
                end
            end
            default: begin
                state_n = T_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        ready = (state_q == T_IDLE);
    end

    assert_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past(value));

    assert_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == T_IDLE) |-> cnt_q == '0);

endmodule

// File: rtl/resv_counter.sv
module resv_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10: if (cnt_q != MAXV) cnt_q <= cnt_q + ONE;
                2'b01: if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
                default: ;
            endcase
        end
    end

    assign count = cnt_q;

    assert_collide_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(cnt_q));

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec && cnt_q == MAXV) |=> cnt_q == MAXV);

    assert_no_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt_q == '0) |=> cnt_q == '0);

endmodule

// File: rtl/issue_resv_timers.sv
module issue_resv_timers
    import resv_pkg::*;
#(
    parameter int NUM_SIMD    = 2,
    parameter int TIMER_W     = 6,
    parameter int CNT_W       = 6,
    parameter int RD_BUS_CYC  = 4,
    parameter int WR_BUS_CYC  = 8,
    localparam int SIMD_W     = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_valid,
    input  logic [SIMD_W-1:0]   issue_simd,
    input  logic [3:0]          issue_class,
    input  logic                flat_shared,
    input  logic [TIMER_W-1:0]  issue_period,
    input  logic [TIMER_W-1:0]  alu_bypass,
    input  logic                dec_total,
    input  logic                dec_gm_rd,
    input  logic                dec_gm_wr,
    input  logic                dec_lm_rd,
    input  logic                dec_lm_wr,
    output logic [NUM_SIMD-1:0] alu_ready,
    output logic [NUM_SIMD-1:0] simd_slot_ready,
    output logic                gm_slot_ready,
    output logic                lm_slot_ready,
    output logic                gm_bus_ready,
    output logic                lm_bus_ready,
    output logic [CNT_W-1:0]    cnt_total,
    output logic [CNT_W-1:0]    cnt_gm_rd,
    output logic [CNT_W-1:0]    cnt_gm_wr,
    output logic [CNT_W-1:0]    cnt_lm_rd,
    output logic [CNT_W-1:0]    cnt_lm_wr
);

    localparam logic [TIMER_W-1:0] RD_LEN = TIMER_W'(RD_BUS_CYC);
    localparam logic [TIMER_W-1:0] WR_LEN = TIMER_W'(WR_BUS_CYC);

    resv_req_t         req;
    logic [TIMER_W-1:0] bus_len;
    logic [NUM_CNT-1:0] inc_vec;
    logic [NUM_CNT-1:0] dec_vec;
    logic [CNT_W-1:0]   cnt_arr [NUM_CNT];

    resv_decode u_decode (
        .issue_valid (issue_valid),
        .issue_class (issue_class),
        .flat_shared (flat_shared),
        .req         (req)
    );

    assign bus_len = req.bus_long ? WR_LEN : RD_LEN;

    for (genvar s = 0; s < NUM_SIMD; s++) begin : g_simd
        logic sel;
        assign sel = (issue_simd == SIMD_W'(s));

        resv_timer #(.W(TIMER_W)) u_alu (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (req.ld_alu && sel),
            .value (alu_bypass),
            .ready (alu_ready[s])
        );

        resv_timer #(.W(TIMER_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (req.ld_simd_slot && sel),
            .value (issue_period),
            .ready (simd_slot_ready[s])
        );
    end

    resv_timer #(.W(TIMER_W)) u_gm_slot (
        .clk (clk), .rst_n (rst_n),
        .load (req.ld_gm_slot), .value (issue_period), .ready (gm_slot_ready)
    );

    resv_timer #(.W(TIMER_W)) u_lm_slot (
        .clk (clk), .rst_n (rst_n),
        .load (req.ld_lm_slot), .value (issue_period), .ready (lm_slot_ready)
    );

    resv_timer #(.W(TIMER_W)) u_gm_bus (
        .clk (clk), .rst_n (rst_n),
        .load (req.ld_gm_bus), .value (bus_len), .ready (gm_bus_ready)
    );

    resv_timer #(.W(TIMER_W)) u_lm_bus (
        .clk (clk), .rst_n (rst_n),
        .load (req.ld_lm_bus), .value (bus_len), .ready (lm_bus_ready)
    );

    always_comb begin
        inc_vec           = '0;
        inc_vec[CI_TOTAL] = req.inc_total;
        inc_vec[CI_GM_RD] = req.inc_gm_rd;
        inc_vec[CI_GM_WR] = req.inc_gm_wr;
        inc_vec[CI_LM_RD] = req.inc_lm_rd;
        inc_vec[CI_LM_WR] = req.inc_lm_wr;
        dec_vec           = '0;
        dec_vec[CI_TOTAL] = dec_total;
        dec_vec[CI_GM_RD] = dec_gm_rd;
        dec_vec[CI_GM_WR] = dec_gm_wr;
        dec_vec[CI_LM_RD] = dec_lm_rd;
        dec_vec[CI_LM_WR] = dec_lm_wr;
    end

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        resv_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[c]),
            .dec   (dec_vec[c]),
            .count (cnt_arr[c])
        );
    end

    assign cnt_total = cnt_arr[CI_TOTAL];
    assign cnt_gm_rd = cnt_arr[CI_GM_RD];
    assign cnt_gm_wr = cnt_arr[CI_GM_WR];
    assign cnt_lm_rd = cnt_arr[CI_LM_RD];
    assign cnt_lm_wr = cnt_arr[CI_LM_WR];

    assert_flat_global_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && (issue_class == OP_FLAT_RD || issue_class == OP_FLAT_WR ||
                         issue_class == OP_PRV_RD || issue_class == OP_PRV_WR ||
                         issue_class == OP_PRV_AT) && !dec_lm_rd && !dec_lm_wr)
        |=> ($stable(cnt_lm_rd) && $stable(cnt_lm_wr)));

    assert_shared_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_class == OP_SHR_RD && issue_period != '0)
        |=> !lm_slot_ready);

endmodule

// File: tb/test_issue_resv_timers.sv
module test_issue_resv_timers;

    localparam int PERIOD   = 10;
    localparam int NS       = 2;
    localparam int TW       = 6;
    localparam int CW       = 4;
    localparam int CMAX     = 15;
    localparam int VW       = 4 * NS + 4 + 5 * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_valid = 1'b0;
    logic [0:0]    issue_simd = '0;
    logic [3:0]    issue_class = '0;
    logic          flat_shared = 1'b0;
    logic [TW-1:0] issue_period = '0;
    logic [TW-1:0] alu_bypass = '0;
    logic          dec_total = 1'b0, dec_gm_rd = 1'b0, dec_gm_wr = 1'b0;
    logic          dec_lm_rd = 1'b0, dec_lm_wr = 1'b0;
    logic [NS-1:0] alu_ready, simd_slot_ready;
    logic          gm_slot_ready, lm_slot_ready, gm_bus_ready, lm_bus_ready;
    logic [CW-1:0] cnt_total, cnt_gm_rd, cnt_gm_wr, cnt_lm_rd, cnt_lm_wr;

    always #(PERIOD / 2) clk = ~clk;

    issue_resv_timers #(.NUM_SIMD(NS), .TIMER_W(TW), .CNT_W(CW)) i_issue_resv_timers (
        .clk (clk), .rst_n (rst_n),
        .issue_valid (issue_valid), .issue_simd (issue_simd),
        .issue_class (issue_class), .flat_shared (flat_shared),
        .issue_period (issue_period), .alu_bypass (alu_bypass),
        .dec_total (dec_total), .dec_gm_rd (dec_gm_rd), .dec_gm_wr (dec_gm_wr),
        .dec_lm_rd (dec_lm_rd), .dec_lm_wr (dec_lm_wr),
        .alu_ready (alu_ready), .simd_slot_ready (simd_slot_ready),
        .gm_slot_ready (gm_slot_ready), .lm_slot_ready (lm_slot_ready),
        .gm_bus_ready (gm_bus_ready), .lm_bus_ready (lm_bus_ready),
        .cnt_total (cnt_total), .cnt_gm_rd (cnt_gm_rd), .cnt_gm_wr (cnt_gm_wr),
        .cnt_lm_rd (cnt_lm_rd), .cnt_lm_wr (cnt_lm_wr)
    );

    // scoreboard
    logic [VW-1:0] exp_q [$];
    string         tag_q [$];
    int            n_checks = 0;
    int            n_fail   = 0;
    bit            done     = 1'b0;

    // reference state built from the requirements
    int m_alu [NS];
    int m_slot [NS];
    int m_gs, m_ls, m_gb, m_lb;
    int m_cnt [5];

    function automatic logic [VW-1:0] pack_model();
        logic [NS-1:0] a, s;
        for (int i = 0; i < NS; i++) begin
            a[i] = (m_alu[i] == 0);
            s[i] = (m_slot[i] == 0);
        end
        return {a, s, m_gs == 0, m_ls == 0, m_gb == 0, m_lb == 0,
                CW'(m_cnt[0]), CW'(m_cnt[1]), CW'(m_cnt[2]),
                CW'(m_cnt[3]), CW'(m_cnt[4])};
    endfunction

    function automatic int tstep(int t, bit ld, int val);
        if (ld) return val;
        if (t != 0) return t - 1;
        return 0;
    endfunction

    task automatic drive(input bit v, input int simd, input int cls, input bit fl,
                         input int per, input int byp, input logic [4:0] dm,
                         input string tag);
        bit ld_alu, ld_ss, ld_gs, ld_ls, ld_gb, ld_lb, mem, rd, wr, loc, cloc;
        logic [4:0] inc;
        int blen;
        issue_valid = v; issue_simd = 1'(simd); issue_class = 4'(cls);
        flat_shared = fl; issue_period = TW'(per); alu_bypass = TW'(byp);
        {dec_lm_wr, dec_lm_rd, dec_gm_wr, dec_gm_rd, dec_total} = dm;
        ld_alu = 0; ld_ss = 0; mem = 0; rd = 0; wr = 0; loc = 0; cloc = 0;
        if (v) begin
            case (cls)
                1: begin ld_alu = 1; ld_ss = 1; end
                2: ld_ss = 1;
                3, 9:  begin mem = 1; rd = 1; end
                4, 10: begin mem = 1; wr = 1; end
                5, 11: begin mem = 1; rd = 1; wr = 1; end
                6: begin mem = 1; rd = 1; loc = 1; cloc = 1; end
                7: begin mem = 1; wr = 1; loc = 1; cloc = 1; end
                8: begin mem = 1; rd = 1; wr = 1; loc = 1; cloc = 1; end
                12: begin mem = 1; rd = 1; loc = fl; end
                13: begin mem = 1; wr = 1; loc = fl; end
                default: ;
            endcase
        end
        blen  = wr ? 8 : 4;
        ld_gs = mem && !loc; ld_ls = mem && loc;
        ld_gb = ld_gs;       ld_lb = ld_ls;
        inc = {mem && wr && cloc, mem && rd && cloc, mem && wr && !cloc,
               mem && rd && !cloc, mem};
        for (int i = 0; i < NS; i++) begin
            m_alu[i]  = tstep(m_alu[i], ld_alu && simd == i, byp);
            m_slot[i] = tstep(m_slot[i], ld_ss && simd == i, per);
        end
        m_gs = tstep(m_gs, ld_gs, per);
        m_ls = tstep(m_ls, ld_ls, per);
        m_gb = tstep(m_gb, ld_gb, blen);
        m_lb = tstep(m_lb, ld_lb, blen);
        for (int c = 0; c < 5; c++) begin
            if (inc[c] && !dm[c] && m_cnt[c] != CMAX) m_cnt[c]++;
            else if (dm[c] && !inc[c] && m_cnt[c] != 0) m_cnt[c]--;
        end
        exp_q.push_back(pack_model());
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 5'b0, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD / 4);
            if (exp_q.size() > 0) begin
                logic [VW-1:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {alu_ready, simd_slot_ready, gm_slot_ready, lm_slot_ready,
                     gm_bus_ready, lm_bus_ready, cnt_total, cnt_gm_rd, cnt_gm_wr,
                     cnt_lm_rd, cnt_lm_wr};
                n_checks++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, a, e);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin m_alu[i] = 0; m_slot[i] = 0; end
        m_gs = 0; m_ls = 0; m_gb = 0; m_lb = 0;
        for (int c = 0; c < 5; c++) m_cnt[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1 reset state");

        drive(1, 0, 1, 0, 3, 5, 5'b0, "R2 alu issue simd0");
        idle(6, "R9 alu countdown");
        drive(1, 1, 2, 0, 4, 7, 5'b0, "R3 barrier simd1");
        idle(5, "R3 barrier countdown");
        drive(1, 0, 1, 0, 0, 0, 5'b0, "R9 zero load");

        drive(1, 0, 3, 0, 2, 0, 5'b0, "R4 R5 R6 global read");
        idle(5, "R4 read bus 4");
        drive(1, 0, 4, 0, 2, 0, 5'b0, "R4 R6 global write");
        idle(9, "R4 write bus 8");
        drive(1, 0, 5, 0, 2, 0, 5'b0, "R6 global atomic");
        idle(9, "R6 atomic drain");
        drive(1, 1, 6, 0, 3, 0, 5'b0, "R5 shared read");
        drive(1, 1, 7, 0, 3, 0, 5'b0, "R13 shared write reload");
        idle(9, "R4 shared drain");
        drive(1, 0, 8, 0, 1, 0, 5'b0, "R6 shared atomic");
        idle(9, "R6 shared atomic drain");
        drive(1, 0, 9, 0, 2, 0, 5'b0, "R7 private read");
        drive(1, 0, 10, 0, 2, 0, 5'b0, "R7 private write");
        drive(1, 0, 11, 0, 2, 0, 5'b0, "R7 private atomic");
        idle(9, "R7 private drain");
        drive(1, 0, 12, 1, 2, 0, 5'b0, "R8 flat shared read");
        idle(5, "R8 flat drain");
        drive(1, 0, 13, 0, 2, 0, 5'b0, "R8 flat global write");
        idle(9, "R8 flat drain");
        drive(1, 0, 13, 1, 2, 0, 5'b0, "R8 flat shared write");
        idle(9, "R8 flat drain");

        drive(1, 0, 0, 0, 5, 5, 5'b0, "R11 nop");
        drive(1, 0, 14, 0, 5, 5, 5'b0, "R11 reserved 14");
        drive(1, 1, 15, 1, 5, 5, 5'b0, "R11 reserved 15");
        drive(0, 0, 1, 0, 5, 5, 5'b0, "R11 valid low");
        drive(0, 0, 4, 0, 5, 5, 5'b0, "R11 valid low mem");
        idle(1, "R11 after");

        drive(1, 0, 3, 0, 1, 0, 5'b00011, "R10 read with completion");
        drive(0, 0, 0, 0, 0, 0, 5'b00100, "R10 decrement alone");
        drive(1, 1, 1, 0, 9, 9, 5'b0, "R13 alu long");
        idle(2, "R13 alu busy");
        drive(1, 1, 1, 0, 2, 2, 5'b0, "R13 alu reload");
        idle(4, "R13 alu after reload");

        for (int i = 0; i < CMAX + 3; i++) drive(1, 0, 3, 0, 1, 0, 5'b0, "R12 saturate high");
        idle(5, "R12 hold max");
        for (int i = 0; i < CMAX + 3; i++) drive(0, 0, 0, 0, 0, 0, 5'b11111, "R12 saturate low");
        idle(3, "R12 hold zero");

        idle(2, "final");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule